// File: doc/BRIEF.md
# Result Bus Slot Scheduler

This block lets several functional units with fixed, different latencies share one result bus without two of them ever writing it in the same cycle. The bus cycle is claimed when an instruction issues, not when its result appears. A shift register holds one slot for each future bus cycle, up to the latency of the slowest unit. An issuing instruction writes its unit number and reorder-buffer tag into the slot that will reach the bus exactly when the unit finishes. If that slot is already taken, the issue is refused and the instruction may try again on the next clock.

Every clock the slots move one position toward the bus end. The slot at the bus end selects, through a one-hot grant vector, the unit that drives the bus in that cycle. It also presents the tag that steers the result into its reorder-buffer entry.

A squash request removes the pending bus claims of instructions that are no longer wanted. It clears every slot whose tag is the given tag or younger, with age measured from the reorder-buffer head. No instruction may issue in the cycle of a squash.

Top module: `result_bus_sched`

## Requirements
- R1: After reset every slot is empty: busValid is 0, busGrant is all zeros, busTag is 0, and issueReady is 1 when no squash is requested.
- R2: The unit latencies are unit 0 = 1, unit 1 = 2, unit 2 = 4 and unit 3 = 6 clocks. An issue accepted in cycle c (issueValid and issueReady both high) puts that unit's grant and the issue tag on the bus in cycle c+L only, where L is the unit's latency.
- R3: If the slot that would reach the bus at cycle c+L already holds a claim, issueReady is low in cycle c. The refused request books nothing, and an unchanged retry in a later cycle is accepted once that slot is free.
- R4: A unit with the longest latency (6) is never refused for lack of a slot. A unit with latency 1 books the bus end directly and is granted in the very next cycle.
- R5: Claims advance one slot per clock. Overlapping issues of different latencies are granted in the order of their completion cycles, which may differ from issue order.
- R6: busGrant has bit u set, and no other bit, when unit u owns the bus. It is all zeros, and busTag is 0, whenever busValid is 0.
- R7: A squash (flushValid) clears every pending claim whose age, (tag − robHead) mod 16, is greater than or equal to the age of flushTag. Older claims are kept.
- R8: issueReady is low in a cycle with flushValid high, and an issue request in that cycle books nothing.
- R9: A squash does not change the grant already on the bus in its own cycle; it affects only the claims still moving toward the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An instruction requests a bus slot this cycle |
| issueUnit | input | 2 | Functional unit of the requesting instruction |
| issueTag | input | 4 | Reorder-buffer tag of the requesting instruction |
| issueReady | output | 1 | The request (if any) is accepted this cycle |
| flushValid | input | 1 | Squash request |
| flushTag | input | 4 | Oldest tag to squash |
| robHead | input | 4 | Reorder-buffer head tag, base for age comparison |
| busValid | output | 1 | A unit owns the result bus this cycle |
| busGrant | output | 4 | One-hot unit select for the result bus |
| busTag | output | 4 | Reorder-buffer entry that receives the bus result |

## Verification
The assertions check several rules on every cycle. A claim that is not squashed moves down one slot per clock. An accepted booking lands in the slot for its latency. A latency-1 booking reaches the bus on the next cycle. The grant stays one-hot or empty, and no issue is accepted during a squash or into an occupied slot. Other behaviour needs the bench's scenarios: the exact cycle at which each unit's grant appears, the reordering of grants from overlapping issues, a refused request that later succeeds, and squash selection by age across tag wraparound, including the grant that is already on the bus.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int unsigned UNITS   = 4;   // functional units sharing the bus
  localparam int unsigned MAX_LAT = 6;   // longest unit latency = slot count
  localparam int unsigned TAG_W   = 4;   // reorder-buffer tag width
  localparam int unsigned UNIT_W  = $clog2(UNITS);
  localparam int unsigned STG_W   = $clog2(MAX_LAT + 1);

  // One pending bus claim.
  typedef struct packed {
    logic              valid;
    logic [UNIT_W-1:0] unit;
    logic [TAG_W-1:0]  tag;
  } slot_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             book;       // write a new claim this clock
    logic [STG_W-1:0] bookStage;  // slot number (1 = bus end) to write
    logic             flush;      // squash young claims while shifting
  } strobe_t;
endpackage

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int unsigned UNIT_LAT [UNITS] = '{1, 2, 4, 6}
) (
  input  logic               issueValid,
  input  logic [UNIT_W-1:0]  issueUnit,
  input  logic               flushValid,
  input  logic [MAX_LAT-1:0] stageValid,  // bit k-1 = slot k occupied
  output logic               issueReady,
  output strobe_t            strobes
);
  logic [STG_W-1:0] reqLat;
  logic             slotTaken;

  // Booking and shifting happen on the same edge, so slot L+1 of the
  // current contents is the one that becomes slot L afterwards.
  always_comb begin
    reqLat    = STG_W'(UNIT_LAT[issueUnit]);
    slotTaken = 1'b0;
    for (int k = 1; k < MAX_LAT; k++) begin
      if (reqLat == STG_W'(k)) slotTaken = stageValid[k];
    end
  end

  assign issueReady        = !flushValid && !slotTaken;
  assign strobes.book      = issueValid && issueReady;
  assign strobes.bookStage = reqLat;
  assign strobes.flush     = flushValid;
endmodule

// File: rtl/rbs_datapath.sv
module rbs_datapath
  import rbs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [UNIT_W-1:0]  issueUnit,
  input  logic [TAG_W-1:0]   issueTag,
  input  logic [TAG_W-1:0]   flushTag,
  input  logic [TAG_W-1:0]   robHead,
  output logic [MAX_LAT-1:0] stageValid,
  output logic               busValid,
  output logic [UNITS-1:0]   busGrant,
  output logic [TAG_W-1:0]   busTag
);
  slot_t [MAX_LAT:1] stage;
  slot_t [MAX_LAT:1] stageNext;
  slot_t             newSlot;
  logic [TAG_W-1:0]  flushAge;

  assign newSlot  = '{valid: 1'b1, unit: issueUnit, tag: issueTag};
  assign flushAge = flushTag - robHead;

  for (genvar k = 1; k <= MAX_LAT; k++) begin : g_stage
    slot_t            upper;
    logic [TAG_W-1:0] upAge;
    logic             squash;
    logic             bookHere;

    if (k == MAX_LAT) begin : g_top
      assign upper = '0;
    end else begin : g_mid
      assign upper = stage[k+1];
    end

    assign upAge    = upper.tag - robHead;
    assign squash   = strobes.flush && (upAge >= flushAge);
    assign bookHere = strobes.book && (strobes.bookStage == STG_W'(k));

    assign stageNext[k] = bookHere ? newSlot
                        : '{valid: upper.valid && !squash,
                            unit:  upper.unit,
                            tag:   upper.tag};

    assign stageValid[k-1] = stage[k].valid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= stageNext;
  end

  assign busValid = stage[1].valid;
  assign busTag   = stage[1].valid ? stage[1].tag : '0;

  always_comb begin
    busGrant = '0;
    if (stage[1].valid) busGrant[stage[1].unit] = 1'b1;
  end
endmodule

// File: rtl/result_bus_sched.sv
module result_bus_sched
  import rbs_pkg::*;
#(
  parameter int unsigned UNIT_LAT [UNITS] = '{1, 2, 4, 6}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [UNIT_W-1:0] issueUnit,
  input  logic [TAG_W-1:0]  issueTag,
  output logic              issueReady,
  input  logic              flushValid,
  input  logic [TAG_W-1:0]  flushTag,
  input  logic [TAG_W-1:0]  robHead,
  output logic              busValid,
  output logic [UNITS-1:0]  busGrant,
  output logic [TAG_W-1:0]  busTag
);
  strobe_t            strobes;
  logic [MAX_LAT-1:0] stageValid;

  rbs_ctrl #(.UNIT_LAT(UNIT_LAT)) u_ctrl (
    .issueValid (issueValid),
    .issueUnit  (issueUnit),
    .flushValid (flushValid),
    .stageValid (stageValid),
    .issueReady (issueReady),
    .strobes    (strobes)
  );

  rbs_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .issueUnit  (issueUnit),
    .issueTag   (issueTag),
    .flushTag   (flushTag),
    .robHead    (robHead),
    .stageValid (stageValid),
    .busValid   (busValid),
    .busGrant   (busGrant),
    .busTag     (busTag)
  );
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker
  import rbs_pkg::*;
#(
  parameter int unsigned UNIT_LAT [UNITS] = '{1, 2, 4, 6}
) (
  input logic               clk,
  input logic               rstN,
  input logic               issueValid,
  input logic [UNIT_W-1:0]  issueUnit,
  input logic [TAG_W-1:0]   issueTag,
  input logic               issueReady,
  input logic               flushValid,
  input logic [MAX_LAT-1:0] stageValid,
  input logic               busValid,
  input logic [UNITS-1:0]   busGrant,
  input logic [TAG_W-1:0]   busTag
);
  logic [STG_W-1:0] lat;
  logic             nextOccupied;
  logic             bookQ;
  logic [STG_W-1:0] latQ;
  logic             landedQ;

  assign lat = STG_W'(UNIT_LAT[issueUnit]);

  always_comb begin
    nextOccupied = 1'b0;
    landedQ      = 1'b0;
    for (int k = 1; k < MAX_LAT; k++)
      if (lat == STG_W'(k)) nextOccupied = stageValid[k];
    for (int k = 1; k <= MAX_LAT; k++)
      if (latQ == STG_W'(k)) landedQ = stageValid[k-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bookQ <= 1'b0;
      latQ  <= '0;
    end else begin
      bookQ <= issueValid && issueReady;
      latQ  <= lat;
    end
  end

  // R2: an accepted claim sits in its latency's slot after the edge
  p_book_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    bookQ |-> landedQ);

  // R3: no acceptance into a slot that is still occupied
  p_busy_refused_r3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && nextOccupied) |-> !issueReady);

  // R4: single-cycle unit is on the bus in the next cycle
  p_lat1_next_r4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && lat == STG_W'(1)) |=>
      (busValid && busTag == $past(issueTag)));

  // R4: longest-latency unit is never refused outside a squash
  p_max_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !flushValid && lat == STG_W'(MAX_LAT)) |-> issueReady);

  // R5: unsquashed claims advance exactly one slot
  for (genvar k = 1; k < MAX_LAT; k++) begin : g_shift
    p_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!flushValid && stageValid[k]) |=> stageValid[k-1]);
  end

  // R6: grant is one-hot when owned, fully quiet otherwise
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> $onehot(busGrant));
  p_grant_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (busGrant == '0 && busTag == '0));

  // R8: no acceptance during a squash
  p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> !issueReady);
endmodule

bind result_bus_sched rbs_checker #(.UNIT_LAT(UNIT_LAT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueUnit  (issueUnit),
  .issueTag   (issueTag),
  .issueReady (issueReady),
  .flushValid (flushValid),
  .stageValid (stageValid),
  .busValid   (busValid),
  .busGrant   (busGrant),
  .busTag     (busTag)
);

// File: tb/result_bus_sched_tb.sv
module result_bus_sched_tb;
  import rbs_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic              rstN;
  logic              issueValid;
  logic [UNIT_W-1:0] issueUnit;
  logic [TAG_W-1:0]  issueTag;
  logic              issueReady;
  logic              flushValid;
  logic [TAG_W-1:0]  flushTag;
  logic [TAG_W-1:0]  robHead;
  logic              busValid;
  logic [UNITS-1:0]  busGrant;
  logic [TAG_W-1:0]  busTag;

  result_bus_sched u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
    .issueTag(issueTag), .issueReady(issueReady), .flushValid(flushValid),
    .flushTag(flushTag), .robHead(robHead), .busValid(busValid),
    .busGrant(busGrant), .busTag(busTag)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cyc;
  int unitLat [UNITS] = '{1, 2, 4, 6};  // from R2

  logic             obsV [0:31];
  logic [UNITS-1:0] obsG [0:31];
  logic [TAG_W-1:0] obsT [0:31];
  logic             obsR [0:31];

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; issueValid = 1'b0; issueUnit = '0; issueTag = '0;
    flushValid = 1'b0; flushTag = '0; robHead = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
  endtask

  // One cycle: drive after the falling edge, sample before the rising edge.
  task automatic drive(input logic iv, input int u, input int t,
                       input logic fv, input int ft, input int hd);
    @(negedge clk);
    issueValid = iv; issueUnit = UNIT_W'(u); issueTag = TAG_W'(t);
    flushValid = fv; flushTag = TAG_W'(ft); robHead = TAG_W'(hd);
    #1;
    obsV[cyc] = busValid; obsG[cyc] = busGrant;
    obsT[cyc] = busTag;   obsR[cyc] = issueReady;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 1'b0, 0, 0);
  endtask

  task automatic checkBus(input int idx, input logic expV, input int expU,
                          input int expT, input string req);
    logic [UNITS-1:0] eg;
    logic [TAG_W-1:0] et;
    eg = expV ? (UNITS'(1) << expU) : '0;
    et = expV ? TAG_W'(expT) : '0;
    checks++;
    if (obsV[idx] !== expV || obsG[idx] !== eg || obsT[idx] !== et) begin
      fails++;
      $display("FAIL %s cycle %0d: valid/grant/tag got %b/%b/%0d expected %b/%b/%0d",
               req, idx, obsV[idx], obsG[idx], obsT[idx], expV, eg, et);
    end
  endtask

  task automatic checkReady(input int idx, input logic exp, input string req);
    checks++;
    if (obsR[idx] !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: issueReady got %b expected %b",
               req, idx, obsR[idx], exp);
    end
  endtask

  task automatic checkQuiet(input int from, input int upto, input string req);
    for (int i = from; i <= upto; i++) checkBus(i, 1'b0, 0, 0, req);
  endtask

  // R1: state after reset
  task automatic testReset();
    doReset();
    idle(2);
    checkBus(0, 1'b0, 0, 0, "R1");
    checkBus(1, 1'b0, 0, 0, "R1");
    checkReady(0, 1'b1, "R1");
  endtask

  // R2, R4, R6: each unit alone, grant at exactly its latency
  task automatic testSingle();
    for (int u = 0; u < UNITS; u++) begin
      doReset();
      drive(1'b1, u, 5 + u, 1'b0, 0, 0);
      idle(7);
      checkReady(0, 1'b1, "R2");
      for (int c = 0; c < 8; c++)
        checkBus(c, c == unitLat[u], u, 5 + u, (u == 0) ? "R4" : "R2");
    end
  endtask

  // R3: occupied slot refuses, retry succeeds
  task automatic testConflict();
    doReset();
    drive(1'b1, 2, 1, 1'b0, 0, 0);  // c0: latency 4 -> bus c4
    idle(1);                        // c1
    drive(1'b1, 1, 2, 1'b0, 0, 0);  // c2: latency 2 would hit c4
    drive(1'b1, 1, 2, 1'b0, 0, 0);  // c3: retry -> bus c5
    idle(4);
    checkReady(2, 1'b0, "R3");
    checkReady(3, 1'b1, "R3");
    checkQuiet(0, 3, "R3");
    checkBus(4, 1'b1, 2, 1, "R3");
    checkBus(5, 1'b1, 1, 2, "R3");
    checkQuiet(6, 7, "R3");
  endtask

  // R4: longest latency never blocked; latency 1 waits for a free bus end
  task automatic testEdges();
    doReset();
    drive(1'b1, 3, 10, 1'b0, 0, 0);  // c0 -> bus c6
    drive(1'b1, 3, 11, 1'b0, 0, 0);  // c1 -> bus c7
    idle(3);                         // c2..c4
    drive(1'b1, 0, 12, 1'b0, 0, 0);  // c5 blocked
    drive(1'b1, 0, 12, 1'b0, 0, 0);  // c6 blocked
    drive(1'b1, 0, 12, 1'b0, 0, 0);  // c7 accepted -> bus c8
    idle(2);
    checkReady(1, 1'b1, "R4");
    checkReady(5, 1'b0, "R4");
    checkReady(6, 1'b0, "R4");
    checkReady(7, 1'b1, "R4");
    checkBus(6, 1'b1, 3, 10, "R4");
    checkBus(7, 1'b1, 3, 11, "R4");
    checkBus(8, 1'b1, 0, 12, "R4");
    checkQuiet(9, 9, "R4");
  endtask

  // R5: overlapping issues complete in reverse issue order
  task automatic testMix();
    doReset();
    drive(1'b1, 3, 1, 1'b0, 0, 0);  // c0 -> c6
    drive(1'b1, 2, 2, 1'b0, 0, 0);  // c1 -> c5
    drive(1'b1, 1, 3, 1'b0, 0, 0);  // c2 -> c4
    for (int i = 0; i < 4; i++) drive(1'b1, 0, 4, 1'b0, 0, 0);  // c3..c6
    idle(2);
    checkReady(2, 1'b1, "R5");
    checkReady(3, 1'b0, "R5");
    checkReady(5, 1'b0, "R5");
    checkReady(6, 1'b1, "R5");
    checkQuiet(0, 3, "R5");
    checkBus(4, 1'b1, 1, 3, "R5");
    checkBus(5, 1'b1, 2, 2, "R5");
    checkBus(6, 1'b1, 3, 1, "R5");
    checkBus(7, 1'b1, 0, 4, "R5");
    checkQuiet(8, 8, "R5");
  endtask

  // R7, R8: squash young claims, issue blocked during squash
  task automatic testFlush();
    doReset();
    drive(1'b1, 3, 2, 1'b0, 0, 0);  // c0 tag2 -> c6, kept
    drive(1'b1, 3, 5, 1'b0, 0, 0);  // c1 tag5 -> c7, squashed
    drive(1'b1, 1, 3, 1'b0, 0, 0);  // c2 tag3 -> c4, squashed
    drive(1'b1, 0, 9, 1'b1, 3, 0);  // c3 squash from tag3, issue refused
    idle(5);
    checkReady(3, 1'b0, "R8");
    checkQuiet(3, 5, "R7");
    checkBus(4, 1'b0, 0, 0, "R8");
    checkBus(6, 1'b1, 3, 2, "R7");
    checkQuiet(7, 8, "R7");
  endtask

  // R7, R9: age compare across wraparound; squash leaves current grant alone
  task automatic testWrap();
    doReset();
    drive(1'b1, 3, 15, 1'b0, 0, 0);  // c0 age 1 -> c6
    drive(1'b1, 3, 1, 1'b0, 0, 0);   // c1 age 3 -> c7
    drive(1'b0, 0, 0, 1'b1, 0, 14);  // c2 squash from age 2
    idle(3);                         // c3..c5
    drive(1'b0, 0, 0, 1'b1, 15, 14); // c6 squash while tag15 on the bus
    idle(2);
    checkQuiet(0, 5, "R7");
    checkBus(6, 1'b1, 3, 15, "R9");
    checkBus(7, 1'b0, 0, 0, "R7");
    checkQuiet(8, 8, "R7");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    issueValid = 1'b0; issueUnit = '0; issueTag = '0;
    flushValid = 1'b0; flushTag = '0; robHead = '0;
    testReset();
    testSingle();
    testConflict();
    testEdges();
    testMix();
    testFlush();
    testWrap();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule